// File: doc/BRIEF.md
# Periodic Timer with Reload-Counting Event Gate

This block is a free-running period timer that counts either down from a period value to zero or up from zero to a period value. It is paired with an 8-bit repeat counter. Each time the timer sits at zero while running, that is a reload point, and the repeat counter tallies it. When the tally reaches a programmed repeat-load value, the repeat counter clears and a repeat-zero pulse is raised.

Two suppression enables use the repeat counter to hold back the timer's zero, load and compare pulses. With the enables set, only one period out of every (repeat-load + 1) periods produces events. This lowers the interrupt rate when the timer drives a periodic waveform. An interrupt controller or another consumer downstream treats each event output as a one-cycle pulse.

The timer value and the repeat-counter value are visible on output ports. Every event output is registered. An event describes the state the block held one cycle before the pulse appears.

Top module: `rep_timer`

## Requirements
- R1: While rst_n is low, cnt, rep_cnt and all four event outputs read 0.
- R2: With en=1 and up_mode=0, cnt decrements by one per clock. A cycle with cnt=0 is followed by cnt=period. The cycle after that shows a load event, unless the load event is suppressed.
- R3: With en=1 and up_mode=1, cnt increments by one per clock. A cycle with cnt=period is followed by cnt=0. The cycle after that shows a load event, unless the load event is suppressed.
- R4: With en=0, cnt and rep_cnt keep their values. No zero or compare event follows such a cycle.
- R5: A reload point is a cycle with en=1 and cnt=0. At a reload point where rep_cnt differs from rep_load, rep_cnt increments by one and wraps modulo 256. In every other cycle, rep_cnt holds.
- R6: At a reload point where rep_cnt equals rep_load, rep_cnt clears to 0 and repz_evt pulses in the following cycle.
- R7: With sup_lz=1, a zero event is passed only at a reload point where rep_cnt equals rep_load. A load event is passed only when rep_cnt is 0 in the cycle the load is presented.
- R8: With sup_cmp=1, a compare event is passed only in cycles where rep_cnt is 0.
- R9: With sup_lz=0, every reload point gives zero_evt in the following cycle, and every reload gives its load event.
- R10: zero_evt pulses in the cycle after a reload point. cmp_evt pulses in the cycle after any cycle with en=1 and cnt=cmp_val, unless the compare event is suppressed.
- R11: A new rep_load value applies at the next reload comparison. If rep_cnt already exceeds the new value, rep_cnt counts through 255 and 0 before it matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Timer run enable |
| up_mode | input | 1 | 1 = count up, 0 = count down |
| period | input | CNT_W | Period / load value |
| cmp_val | input | CNT_W | Compare value |
| rep_load | input | RC_W | Repeat-load value |
| sup_lz | input | 1 | Suppress zero and load events while repeating |
| sup_cmp | input | 1 | Suppress compare events while repeating |
| zero_evt | output | 1 | Qualified zero event pulse |
| load_evt | output | 1 | Qualified load event pulse |
| cmp_evt | output | 1 | Qualified compare event pulse |
| repz_evt | output | 1 | Repeat-counter-zero pulse |
| cnt | output | CNT_W | Current timer value |
| rep_cnt | output | RC_W | Current repeat-counter value |

## Verification
cnt and rep_cnt take their new values on the same rising edge that samples the inputs. The zero, compare and repeat-zero pulses appear one edge after the cycle that caused them. A load pulse appears one edge after the reload, so it comes two edges after the zero or wrap cycle. The bench advances its model once per rising edge from the inputs and state that held before that edge. It compares every output at the following falling edge and drives new inputs only after that comparison, so each result is read in exactly the cycle it is due.

// File: rtl/rt_pkg.sv
package rt_pkg;

    typedef struct packed {
        logic zero;
        logic load;
        logic cmp;
        logic repz;
    } rt_evt_t;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } rt_dir_e;

endpackage

// File: rtl/rt_counter.sv
module rt_counter
    import rt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             up_mode,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] cmp_val,
    output logic [CNT_W-1:0] cnt,
    output logic             reload_pt,
    output logic             raw_load,
    output logic             raw_cmp
);

    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] ZERO = '0;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             loaded;
    } cnt_state_t;

    cnt_state_t s_d, s_q;
    rt_dir_e    dir;
    logic       at_zero;
    logic       at_top;

    always_comb begin
        dir       = rt_dir_e'(up_mode);
        at_zero   = (s_q.cnt == ZERO);
        at_top    = (s_q.cnt == period);
        s_d       = s_q;
        s_d.loaded = 1'b0;
        if (en) begin
            if (dir == DIR_DOWN) begin
                if (at_zero) begin
                    s_d.cnt    = period;
                    s_d.loaded = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt - ONE;
                end
            end else begin
                if (at_top) begin
                    s_d.cnt    = ZERO;
                    s_d.loaded = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + ONE;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt       = s_q.cnt;
    assign reload_pt = en && at_zero;
    assign raw_load  = s_q.loaded;
    assign raw_cmp   = en && (s_q.cnt == cmp_val);

    // R4: a stopped timer keeps its value
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(cnt));

    // R2: nonzero value steps down by one
    p_down_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !up_mode && cnt != ZERO) |=> (cnt == $past(cnt) - ONE));

    // R2: zero reloads the period and flags a load
    p_down_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !up_mode && cnt == ZERO) |=> (cnt == $past(period) && raw_load));

    // R3: top value wraps to zero
    p_up_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && up_mode && cnt == period) |=> (cnt == ZERO && raw_load));

endmodule

// File: rtl/rt_repeat.sv
module rt_repeat #(
    parameter int RC_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reload_pt,
    input  logic [RC_W-1:0] rep_load,
    output logic [RC_W-1:0] rc,
    output logic            match,
    output logic            rc_zero
);

    localparam logic [RC_W-1:0] RC_ONE = {{(RC_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [RC_W-1:0] rc;
    } rep_state_t;

    rep_state_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (reload_pt) begin
            if (r_q.rc == rep_load) begin
                r_d.rc = '0;
            end else begin
                r_d.rc = r_q.rc + RC_ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rc      = r_q.rc;
    assign match   = (r_q.rc == rep_load);
    assign rc_zero = (r_q.rc == '0);

    // R5: no reload point, no movement
    p_rc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !reload_pt |=> $stable(rc));

    // R5: unmatched reload advances by one
    p_rc_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_pt && rc != rep_load) |=> (rc == $past(rc) + RC_ONE));

    // R6: matched reload clears
    p_rc_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_pt && rc == rep_load) |=> rc_zero);

endmodule

// File: rtl/rt_gate.sv
module rt_gate
    import rt_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    reload_pt,
    input  logic    raw_load,
    input  logic    raw_cmp,
    input  logic    match,
    input  logic    rc_zero,
    input  logic    sup_lz,
    input  logic    sup_cmp,
    output rt_evt_t evt
);

    rt_evt_t e_d, e_q;
    logic    lz_open_zero;
    logic    lz_open_load;
    logic    cmp_open;

    always_comb begin
        lz_open_zero = !sup_lz || match;
        lz_open_load = !sup_lz || rc_zero;
        cmp_open     = !sup_cmp || rc_zero;
        e_d.zero     = reload_pt && lz_open_zero;
        e_d.load     = raw_load && lz_open_load;
        e_d.cmp      = raw_cmp && cmp_open;
        e_d.repz     = reload_pt && match;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_q <= '0;
        end else begin
            e_q <= e_d;
        end
    end

    assign evt = e_q;

    // R7: a suppressed-mode zero event only comes with the repeat-zero pulse
    p_zero_qual_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sup_lz) && evt.zero) |-> evt.repz);

    // R8: a suppressed-mode compare event only while the repeat counter was idle
    p_cmp_qual_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sup_cmp) && evt.cmp) |-> $past(rc_zero));

    // R9: without suppression each reload point yields a zero event
    p_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sup_lz && reload_pt) |=> evt.zero);

endmodule

// File: rtl/rep_timer.sv
module rep_timer
    import rt_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int RC_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             up_mode,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic [RC_W-1:0]  rep_load,
    input  logic             sup_lz,
    input  logic             sup_cmp,
    output logic             zero_evt,
    output logic             load_evt,
    output logic             cmp_evt,
    output logic             repz_evt,
    output logic [CNT_W-1:0] cnt,
    output logic [RC_W-1:0]  rep_cnt
);

    logic    reload_pt;
    logic    raw_load;
    logic    raw_cmp;
    logic    match;
    logic    rc_zero;
    rt_evt_t evt;

    rt_counter #(.CNT_W(CNT_W)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .up_mode   (up_mode),
        .period    (period),
        .cmp_val   (cmp_val),
        .cnt       (cnt),
        .reload_pt (reload_pt),
        .raw_load  (raw_load),
        .raw_cmp   (raw_cmp)
    );

    rt_repeat #(.RC_W(RC_W)) u_repeat (
        .clk       (clk),
        .rst_n     (rst_n),
        .reload_pt (reload_pt),
        .rep_load  (rep_load),
        .rc        (rep_cnt),
        .match     (match),
        .rc_zero   (rc_zero)
    );

    rt_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .reload_pt (reload_pt),
        .raw_load  (raw_load),
        .raw_cmp   (raw_cmp),
        .match     (match),
        .rc_zero   (rc_zero),
        .sup_lz    (sup_lz),
        .sup_cmp   (sup_cmp),
        .evt       (evt)
    );

    assign zero_evt = evt.zero;
    assign load_evt = evt.load;
    assign cmp_evt  = evt.cmp;
    assign repz_evt = evt.repz;

    // R6: the repeat-zero pulse coincides with a cleared repeat counter
    p_repz_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        repz_evt |-> (rep_cnt == '0));

    // R4: a stopped cycle gives no zero or compare event next
    p_stop_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!zero_evt && !cmp_evt));

endmodule

// File: tb/tb_rep_timer.sv
module tb_rep_timer;

    localparam int CNT_W = 16;
    localparam int RC_W  = 8;
    localparam int MAX_CYCLES = 150000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en = 1'b0;
    logic             up_mode = 1'b0;
    logic [CNT_W-1:0] period = '0;
    logic [CNT_W-1:0] cmp_val = '0;
    logic [RC_W-1:0]  rep_load = '0;
    logic             sup_lz = 1'b0;
    logic             sup_cmp = 1'b0;
    logic             zero_evt, load_evt, cmp_evt, repz_evt;
    logic [CNT_W-1:0] cnt;
    logic [RC_W-1:0]  rep_cnt;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // model state
    logic [CNT_W-1:0] m_cnt;
    logic             m_loaded;
    logic [RC_W-1:0]  m_rc;
    logic             x_zero, x_load, x_cmp, x_repz;

    rep_timer #(.CNT_W(CNT_W), .RC_W(RC_W)) dut (
        .clk(clk), .rst_n(rst_n), .en(en), .up_mode(up_mode),
        .period(period), .cmp_val(cmp_val), .rep_load(rep_load),
        .sup_lz(sup_lz), .sup_cmp(sup_cmp),
        .zero_evt(zero_evt), .load_evt(load_evt), .cmp_evt(cmp_evt),
        .repz_evt(repz_evt), .cnt(cnt), .rep_cnt(rep_cnt)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_cnt = '0; m_loaded = 1'b0; m_rc = '0;
        x_zero = 1'b0; x_load = 1'b0; x_cmp = 1'b0; x_repz = 1'b0;
    endtask

    function automatic logic [CNT_W-1:0] next_cnt(input logic [CNT_W-1:0] c);
        if (!en) return c;
        if (up_mode) return (c == period) ? '0 : c + 1'b1;
        return (c == '0) ? period : c - 1'b1;
    endfunction

    task automatic model_advance();
        logic reload, hit;
        reload   = en && (m_cnt == '0);
        hit      = (m_rc == rep_load);
        x_zero   = reload && (!sup_lz || hit);
        x_load   = m_loaded && (!sup_lz || m_rc == '0);
        x_cmp    = en && (m_cnt == cmp_val) && (!sup_cmp || m_rc == '0);
        x_repz   = reload && hit;
        m_loaded = en && (up_mode ? (m_cnt == period) : (m_cnt == '0));
        m_cnt    = next_cnt(m_cnt);
        if (reload) m_rc = hit ? '0 : m_rc + 1'b1;
    endtask

    task automatic compare_all();
        chk(!en ? "R4" : (up_mode ? "R3" : "R2"), "cnt", 32'(cnt), 32'(m_cnt));
        chk("R5", "rep_cnt", 32'(rep_cnt), 32'(m_rc));
        chk("R6", "repz_evt", 32'(repz_evt), 32'(x_repz));
        chk(sup_lz ? "R7" : "R9", "zero_evt", 32'(zero_evt), 32'(x_zero));
        chk(sup_lz ? "R7" : "R9", "load_evt", 32'(load_evt), 32'(x_load));
        chk(sup_cmp ? "R8" : "R10", "cmp_evt", 32'(cmp_evt), 32'(x_cmp));
    endtask

    task automatic step();
        @(posedge clk);
        if (rst_n) model_advance(); else model_reset();
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        #(MAX_CYCLES * 5);
        if (!finished) begin
            finished = 1'b1;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int repz_seen;
        logic [CNT_W-1:0] held;
        void'($urandom(32'd20240611));
        model_reset();
        en = 1'b1; period = 16'd5; rep_load = 8'd3; sup_lz = 1'b1;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1", "cnt", 32'(cnt), 0);
        chk("R1", "rep_cnt", 32'(rep_cnt), 0);
        chk("R1", "events", 32'({zero_evt, load_evt, cmp_evt, repz_evt}), 0);
        rst_n = 1'b1;

        // directed: suppressed down-count, rep_load 3
        cmp_val = 16'd2; sup_cmp = 1'b1;
        repeat (60) step();

        // R4: stop the timer and confirm it holds
        en = 1'b0;
        held = cnt;
        repeat (20) step();
        chk("R4", "cnt held", 32'(cnt), 32'(held));

        // R11: lower rep_load below the current tally
        en = 1'b1; up_mode = 1'b0; period = '0; rep_load = 8'd10;
        for (int i = 0; i < 40 && rep_cnt != 8'd6; i++) step();
        chk("R11", "rep_cnt reached", 32'(rep_cnt), 6);
        rep_load = 8'd2;
        repz_seen = 0;
        for (int i = 0; i < 253; i++) begin
            step();
            if (repz_evt) repz_seen++;
        end
        chk("R11", "repz count", 32'(repz_seen), 1);
        chk("R11", "rep_cnt after wrap", 32'(rep_cnt), 0);

        // random phases
        for (int ph = 0; ph < 60; ph++) begin
            int len;
            bit jitter;
            up_mode  = $urandom_range(0, 1);
            period   = 16'($urandom_range(0, 7));
            cmp_val  = 16'($urandom_range(0, 7));
            rep_load = ($urandom_range(0, 3) == 0) ? 8'd0 : 8'($urandom_range(1, 5));
            sup_lz   = $urandom_range(0, 1);
            sup_cmp  = $urandom_range(0, 1);
            jitter   = ($urandom_range(0, 2) == 0);
            len      = $urandom_range(100, 300);
            if (up_mode && cnt > period) begin
                up_mode = 1'b0;
            end
            for (int c = 0; c < len; c++) begin
                en = jitter ? ($urandom_range(0, 7) != 0) : 1'b1;
                step();
            end
        end

        // R1: second reset mid-run
        rst_n = 1'b0;
        step();
        chk("R1", "cnt after reset", 32'(cnt), 0);
        chk("R1", "rep_cnt after reset", 32'(rep_cnt), 0);

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule